// File: doc/BRIEF.md
# Graphics Core Event Interrupt Controller

This block gathers the completion and fault events of one graphics core and turns them into a single level interrupt. There are five sources: binner finished, renderer finished, compute finished, binner out of overflow memory, and memory-protection violation. Each event is held in a pending-status register until software acknowledges it by writing ones to a clear register. A mask register chooses which pending events may raise the interrupt line. Software changes the mask through two write ports: one disables sources and the other enables them.

Out-of-memory is driven by a level from the binner that says it needs memory. The block raises the out-of-memory event once for each supply of overflow memory. It will not raise the event again until software writes a new pool size, even if the need stays high. While that condition is outstanding, binner completions are held back. They become visible in the cycle the new pool size is written. The pool base and size that software writes are driven out to the binner, together with a one-cycle load strobe.

Top module: `gjic_ctrl`

## Requirements
- R1: Status bit 0 is out-of-memory, bit 1 is binner done, bit 2 is render done, bit 3 is compute done and bit 4 is protection violation. A source event sets its bit even while that source is masked.
- R2: Writing a value to the clear register (address 1) clears exactly the status bits that are one in that value and leaves all other bits unchanged.
- R3: Writing ones to mask-set (address 2) disables those sources, and writing ones to mask-clear (address 3) enables them. The mask reads back at address 4, where bit value 1 means disabled. The mask resets to all ones.
- R4: `irq` is the OR of status AND NOT mask, registered. It changes one cycle after the status or mask changes.
- R5: When a source event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: Out-of-memory is raised when `bin_need_mem` is high and memory is armed. Memory is armed at reset and by each pool-size write. Once the event is raised, it is not raised again until the next pool-size write, even if the need stays high or falls and rises again.
- R7: A binner completion that arrives while out-of-memory is outstanding does not set bit 1. It is held, and bit 1 is set in the cycle the pool size is written. With no outstanding out-of-memory, a completion sets bit 1 at once.
- R8: The pool base (address 5) and pool size (address 6) are writable and read back. They drive `pool_base` and `pool_size`. A size write pulses `pool_load` for one cycle.
- R9: Status reads back at address 0. `reg_rdata` is registered from `reg_addr`, and unmapped addresses read as zero.
- R10: Writing all ones to mask-set and then all five bits to clear leaves status zero and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | DATA_W | Registered read data |
| bin_done | input | 1 | Binner completion pulse |
| rnd_done | input | 1 | Renderer completion pulse |
| cmp_done | input | 1 | Compute completion pulse |
| prot_viol | input | 1 | Protection violation pulse |
| bin_need_mem | input | 1 | Binner needs overflow memory (level) |
| pool_base | output | DATA_W | Overflow pool base |
| pool_size | output | DATA_W | Overflow pool size |
| pool_load | output | 1 | One-cycle strobe on a pool-size write |
| irq | output | 1 | Level interrupt |

## Verification
The mask path is tried in two ways. A masked event is followed by an unmask write, which shows that status is latched apart from the mask. A clear that covers only some pending bits shows that the clear is exact, bit by bit, and not a wholesale reset. A source event and a clear write are aimed at the same bit in the same cycle to show that set has priority. The out-of-memory sequence holds the need high, then drops it and raises it again before any pool write, and it slips a binner completion in between. This separates edge-once signalling from level signalling, and a held completion from one that is lost or passed through early.

// File: rtl/gjic_pkg.sv
package gjic_pkg;
  localparam int NSRC = 5;
  localparam int B_OOM  = 0;
  localparam int B_BIN  = 1;
  localparam int B_RND  = 2;
  localparam int B_CMP  = 3;
  localparam int B_PROT = 4;

  localparam int A_STATUS = 0;
  localparam int A_CLEAR  = 1;
  localparam int A_MSET   = 2;
  localparam int A_MCLR   = 3;
  localparam int A_MASK   = 4;
  localparam int A_PBASE  = 5;
  localparam int A_PSIZE  = 6;
endpackage

// File: rtl/gjic_regif.sv
module gjic_regif
  import gjic_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic [NSRC-1:0]   status,
  input  logic [NSRC-1:0]   mask,
  output logic [NSRC-1:0]   clr_vec,
  output logic [NSRC-1:0]   mset_vec,
  output logic [NSRC-1:0]   mclr_vec,
  output logic              size_wr,
  output logic [DATA_W-1:0] pool_base,
  output logic [DATA_W-1:0] pool_size,
  output logic              pool_load,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - NSRC;

  logic hit_clr, hit_mset, hit_mclr, hit_base;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    hit_clr  = reg_we && (reg_addr == ADDR_W'(A_CLEAR));
    hit_mset = reg_we && (reg_addr == ADDR_W'(A_MSET));
    hit_mclr = reg_we && (reg_addr == ADDR_W'(A_MCLR));
    hit_base = reg_we && (reg_addr == ADDR_W'(A_PBASE));
    size_wr  = reg_we && (reg_addr == ADDR_W'(A_PSIZE));
    clr_vec  = hit_clr  ? reg_wdata[NSRC-1:0] : '0;
    mset_vec = hit_mset ? reg_wdata[NSRC-1:0] : '0;
    mclr_vec = hit_mclr ? reg_wdata[NSRC-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pool_base <= '0;
      pool_size <= '0;
      pool_load <= 1'b0;
    end else begin
      if (hit_base) pool_base <= reg_wdata;
      if (size_wr)  pool_size <= reg_wdata;
      pool_load <= size_wr;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(A_STATUS): rd_next = {{PAD_W{1'b0}}, status};
      ADDR_W'(A_MASK):   rd_next = {{PAD_W{1'b0}}, mask};
      ADDR_W'(A_PBASE):  rd_next = pool_base;
      ADDR_W'(A_PSIZE):  rd_next = pool_size;
      default:           rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pool_load |-> !$past(pool_load) || $past(size_wr)); // R8
endmodule

// File: rtl/gjic_mask.sv
module gjic_mask
  import gjic_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] mset_vec,
  input  logic [NSRC-1:0] mclr_vec,
  output logic [NSRC-1:0] mask
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              mask[i] <= 1'b1;
      else if (mset_vec[i]) mask[i] <= 1'b1;
      else if (mclr_vec[i]) mask[i] <= 1'b0;
    end

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
      mset_vec[i] |=> mask[i]); // R3
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
      (mclr_vec[i] && !mset_vec[i]) |=> !mask[i]); // R3
  end

  AST_MASK_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == '1)); // R3
endmodule

// File: rtl/gjic_status.sv
module gjic_status
  import gjic_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] status
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             status[i] <= 1'b0;
      else if (set_vec[i]) status[i] <= 1'b1;
      else if (clr_vec[i]) status[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> status[i]); // R5
    AST_W1C_EXACT: assert property (@(posedge clk) disable iff (rst)
      (!set_vec[i] && !clr_vec[i]) |=> $stable(status[i])); // R2
  end
endmodule

// File: rtl/gjic_oom_track.sv
module gjic_oom_track (
  input  logic clk,
  input  logic rst,
  input  logic need_mem,
  input  logic bin_pulse,
  input  logic size_wr,
  output logic oom_set,
  output logic bin_set
);
  logic armed, held, bin_blocked;

  always_comb begin
    oom_set     = armed && need_mem;
    bin_blocked = bin_pulse && !armed;
    bin_set     = (bin_pulse && armed) || (size_wr && (held || bin_blocked));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      held  <= 1'b0;
    end else begin
      if (oom_set)      armed <= 1'b0;
      else if (size_wr) armed <= 1'b1;
      if (size_wr)          held <= 1'b0;
      else if (bin_blocked) held <= 1'b1;
    end
  end

  AST_OOM_ONCE: assert property (@(posedge clk) disable iff (rst)
    oom_set |=> !oom_set); // R6
  AST_OOM_WAITS: assert property (@(posedge clk) disable iff (rst)
    (!armed && !size_wr) |=> !oom_set); // R6
  AST_BIN_HELD: assert property (@(posedge clk) disable iff (rst)
    (bin_blocked && !size_wr) |=> held); // R7
  AST_BIN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (held && size_wr) |-> bin_set); // R7
endmodule

// File: rtl/gjic_ctrl.sv
module gjic_ctrl
  import gjic_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bin_done,
  input  logic              rnd_done,
  input  logic              cmp_done,
  input  logic              prot_viol,
  input  logic              bin_need_mem,
  output logic [DATA_W-1:0] pool_base,
  output logic [DATA_W-1:0] pool_size,
  output logic              pool_load,
  output logic              irq
);
  logic [NSRC-1:0] status, mask, clr_vec, mset_vec, mclr_vec, set_vec;
  logic size_wr, oom_set, bin_set;

  gjic_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .status(status), .mask(mask), .clr_vec(clr_vec),
    .mset_vec(mset_vec), .mclr_vec(mclr_vec), .size_wr(size_wr),
    .pool_base(pool_base), .pool_size(pool_size), .pool_load(pool_load),
    .rdata(reg_rdata)
  );

  gjic_oom_track u_oom (
    .clk(clk), .rst(rst), .need_mem(bin_need_mem), .bin_pulse(bin_done),
    .size_wr(size_wr), .oom_set(oom_set), .bin_set(bin_set)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_OOM]  = oom_set;
    set_vec[B_BIN]  = bin_set;
    set_vec[B_RND]  = rnd_done;
    set_vec[B_CMP]  = cmp_done;
    set_vec[B_PROT] = prot_viol;
  end

  gjic_status u_status (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .status(status)
  );

  gjic_mask u_mask (
    .clk(clk), .rst(rst), .mset_vec(mset_vec), .mclr_vec(mclr_vec), .mask(mask)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & ~mask);
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(status & ~mask))); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(mask) == '1) |-> !irq); // R4
endmodule

// File: tb/gjic_ctrl_test.sv
module gjic_ctrl_test;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [DW-1:0] reg_rdata;
  logic bin_done = 0, rnd_done = 0, cmp_done = 0, prot_viol = 0, bin_need_mem = 0;
  logic [DW-1:0] pool_base, pool_size;
  logic pool_load, irq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  gjic_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .bin_done(bin_done),
    .rnd_done(rnd_done), .cmp_done(cmp_done), .prot_viol(prot_viol),
    .bin_need_mem(bin_need_mem), .pool_base(pool_base), .pool_size(pool_size),
    .pool_load(pool_load), .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R4 irq after reset", DW'(irq), 0);
    rd(0, v); check("R9 status after reset", v, 0);
    rd(4, v); check("R3 mask after reset", v, 32'h1F);
    rd(7, v); check("R9 unmapped read", v, 0);
  endtask

  task automatic t_masked_event();
    logic [DW-1:0] v;
    @(negedge clk); rnd_done = 1;
    @(negedge clk); rnd_done = 0;
    idle(1);
    check("R4 masked event keeps irq low", DW'(irq), 0);
    rd(0, v); check("R1 render bit set while masked", v, 32'h04);
    wr(3, 32'h04);
    idle(1);
    check("R4 irq after unmask", DW'(irq), 1);
    rd(4, v); check("R3 mask after mask-clear", v, 32'h1B);
    wr(1, 32'h04);
    idle(1);
    check("R2 irq low after clear", DW'(irq), 0);
    rd(0, v); check("R2 status after clear", v, 0);
  endtask

  task automatic t_partial_clear();
    logic [DW-1:0] v;
    @(negedge clk); cmp_done = 1; prot_viol = 1;
    @(negedge clk); cmp_done = 0; prot_viol = 0;
    rd(0, v); check("R1 compute and violation bits", v, 32'h18);
    wr(1, 32'h08);
    rd(0, v); check("R2 exact bit clear", v, 32'h10);
    wr(2, 32'h04);
    rd(4, v); check("R3 mask-set disables", v, 32'h1F);
    wr(1, 32'h10);
  endtask

  task automatic t_set_wins();
    logic [DW-1:0] v;
    @(negedge clk); cmp_done = 1;
    reg_addr = AW'(1); reg_wdata = 32'h08; reg_we = 1'b1;
    @(negedge clk); cmp_done = 0; reg_we = 1'b0;
    rd(0, v); check("R5 set beats clear", v, 32'h08);
    wr(1, 32'h1F);
  endtask

  task automatic t_oom();
    logic [DW-1:0] v;
    wr(3, 32'h1F);
    @(negedge clk); bin_need_mem = 1;
    @(negedge clk);
    rd(0, v); check("R6 oom raised", v, 32'h01);
    check("R4 irq on oom", DW'(irq), 1);
    wr(1, 32'h01);
    idle(3);
    rd(0, v); check("R6 no re-raise while need held", v, 0);
    bin_need_mem = 0; idle(2); bin_need_mem = 1; idle(2);
    rd(0, v); check("R6 no re-raise on new need edge", v, 0);
    @(negedge clk); bin_done = 1;
    @(negedge clk); bin_done = 0;
    rd(0, v); check("R7 binner done held back", v, 0);
    bin_need_mem = 0;
    wr(5, 32'h0004_0000);
    wr(6, 32'h0004_0000);
    check("R8 pool_load strobe", DW'(pool_load), 1);
    @(negedge clk);
    check("R8 pool_load one cycle", DW'(pool_load), 0);
    rd(0, v); check("R7 held done released", v, 32'h02);
    check("R8 pool_base out", pool_base, 32'h0004_0000);
    rd(6, v); check("R8 pool size readback", v, 32'h0004_0000);
    wr(1, 32'h02);
    @(negedge clk); bin_done = 1;
    @(negedge clk); bin_done = 0;
    rd(0, v); check("R7 direct done when armed", v, 32'h02);
    @(negedge clk); bin_need_mem = 1;
    @(negedge clk); bin_need_mem = 0;
    rd(0, v); check("R6 oom raised after new pool", v, 32'h03);
  endtask

  task automatic t_init_seq();
    logic [DW-1:0] v;
    @(negedge clk); prot_viol = 1;
    @(negedge clk); prot_viol = 0;
    wr(2, 32'hFFFF_FFFF);
    wr(1, 32'h1F);
    idle(1);
    check("R10 irq low after init", DW'(irq), 0);
    rd(0, v); check("R10 status zero after init", v, 0);
    rd(4, v); check("R10 mask all set", v, 32'h1F);
  endtask

  initial begin
    fork
      begin
        idle(3);
        @(negedge clk); rst = 0;
        t_reset();
        t_masked_event();
        t_partial_clear();
        t_set_wins();
        t_oom();
        t_init_seq();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule